// File: doc/BRIEF.md
# Stopwatch Button Control State Machine

This block turns four debounced push-button levels (start, stop, increment, clear) into the three control signals of a stopwatch counter datapath. The first is a run enable: while it is high, the counter advances on its millisecond tick. The second is a one-cycle step strobe that advances the count by one. The third is a one-cycle clear pulse that returns the count to zero.

The block holds one bit of state, running or stopped, and resolves buttons pressed together by a fixed priority: clear, then stop, then start, then increment. Increment and clear act on the rising edge of their level only. A button held for any length of time therefore acts once, and it has to be released before it can act again. This also applies to a button that is still held when reset is released. All outputs are registered, so each one responds on the clock edge that samples the button.

Top module: `sw_ctrl`

## Requirements
- R1: While rst_ni is low, run_o, step_o and clear_o are 0. An increment or clear button held through reset release causes no step_o or clear_o until it has been released and pressed again.
- R2: When start_i is sampled high and stop_i and clear_i are low, run_o is 1 after that clock edge. It stays 1 until stop or clear is sampled.
- R3: When stop_i is sampled high and clear_i is low, run_o is 0 after that clock edge, even if start_i is also high.
- R4: A 0-to-1 change of clear_i gives exactly one cycle of clear_o, starting at the edge that samples it. Whenever clear_i is sampled high, run_o is 0 after that edge, even if start_i is also high.
- R5: A 0-to-1 change of incr_i, sampled while run_o is 0 and with start_i, stop_i and clear_i all low, gives exactly one cycle of step_o. Holding incr_i high for further cycles gives no further step_o.
- R6: incr_i produces no step_o while run_o is 1, or in a cycle where start_i, stop_i or clear_i is high. A press that was ignored gives no step_o later while it is still held.
- R7: step_o and clear_o are never 1 in the same cycle, and neither lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start button level (debounced) |
| stop_i | input | 1 | Stop button level (debounced) |
| incr_i | input | 1 | Increment button level (debounced) |
| clear_i | input | 1 | Clear button level (debounced) |
| run_o | output | 1 | Run enable for the counter |
| step_o | output | 1 | One-cycle single-step strobe |
| clear_o | output | 1 | One-cycle counter clear pulse |

## Verification
A wrong run state appears on run_o one edge after the button that should have set it. Because increment is gated by that state, the fault also shows as a step_o that is present or missing on the next increment press. A faulty edge-detector register shows up either as repeated strobes while a button is held, or as a strobe when a held button comes out of reset or out of a running period. The stimulus therefore holds buttons across reset release, across stop, and together with each higher-priority button, and it compares every output on the edge after each stimulus.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
  typedef enum logic [0:0] {
    ST_STOPPED = 1'b0,
    ST_RUNNING = 1'b1
  } sw_state_e;

  // bit positions of the edge-qualified buttons
  localparam int unsigned EDGE_W   = 2;
  localparam int unsigned EDGE_INC = 0;
  localparam int unsigned EDGE_CLR = 1;
endpackage

// File: rtl/sw_edge_det.sv
module sw_edge_det #(
  parameter int unsigned WIDTH   = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= RST_VAL;
      else         prev_q[g] <= level_i[g];
    end
    assign rise_o[g] = level_i[g] & ~prev_q[g];

    AST_RISE_NEEDS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]); // R7
  end
endmodule

// File: rtl/sw_run_fsm.sv
module sw_run_fsm
  import sw_ctrl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      clear_i,
  output sw_state_e state_o
);
  sw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clear_i || stop_i) state_d = ST_STOPPED;
    else if (start_i)      state_d = ST_RUNNING;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_STOPPED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_CLEAR_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> state_q == ST_STOPPED); // R4
  AST_STOP_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_q == ST_STOPPED); // R3
  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !clear_i) |=> state_q == ST_RUNNING); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i && !clear_i) |=> $stable(state_q)); // R2
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic incr_i,
  input  logic clear_i,
  output logic run_o,
  output logic step_o,
  output logic clear_o
);
  logic [EDGE_W-1:0] lvl, rise;
  sw_state_e         state;
  logic              step_d;
  logic              step_q, clear_q;

  assign lvl[EDGE_INC] = incr_i;
  assign lvl[EDGE_CLR] = clear_i;

  // reset value 1: a button held through reset must be released first
  sw_edge_det #(.WIDTH(EDGE_W), .RST_VAL(1'b1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(lvl),
    .rise_o (rise)
  );

  sw_run_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .stop_i (stop_i),
    .clear_i(clear_i),
    .state_o(state)
  );

  // step only when stopped and no higher-priority button is pressed
  assign step_d = rise[EDGE_INC] && (state == ST_STOPPED) && !clear_i && !stop_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      step_q  <= step_d;
      clear_q <= rise[EDGE_CLR];
    end
  end

  assign run_o   = (state == ST_RUNNING);
  assign step_o  = step_q;
  assign clear_o = clear_q;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!run_o && !step_o && !clear_o)); // R1
  AST_STEP_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> !run_o); // R6
  AST_STEP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o); // R5
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !clear_o); // R4
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({step_o, clear_o})); // R7
endmodule

// File: tb/sw_ctrl_tb.sv
`timescale 1ns/1ps
module sw_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, incr = 1'b0, clr = 1'b0;
  logic run, step, clr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic run;
    logic step;
    logic clr;
    string req;
  } exp_t;

  exp_t q[$];

  // reference model state
  logic m_run = 1'b0, m_inc_prev = 1'b1, m_clr_prev = 1'b1;

  always #2.5 clk = ~clk;

  sw_ctrl u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .start_i(start),
    .stop_i (stop),
    .incr_i (incr),
    .clear_i(clr),
    .run_o  (run),
    .step_o (step),
    .clear_o(clr_o)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (run !== e.run || step !== e.step || clr_o !== e.clr) begin
      fails++;
      $display("FAIL %s: run/step/clear actual %b%b%b expected %b%b%b",
               e.req, run, step, clr_o, e.run, e.step, e.clr);
    end
  endtask

  task automatic drive(input logic s, input logic p, input logic i, input logic c, input string req);
    exp_t e;
    @(negedge clk);
    start = s; stop = p; incr = i; clr = c;
    e.clr  = c & ~m_clr_prev;
    e.step = ~m_run & i & ~m_inc_prev & ~c & ~p & ~s;
    if (c || p) m_run = 1'b0;
    else if (s) m_run = 1'b1;
    e.run = m_run;
    e.req = req;
    m_inc_prev = i;
    m_clr_prev = c;
    q.push_back(e);
  endtask

  // monitor: compare one item after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    exp_t r;
    incr = 1'b1; clr = 1'b1;
    repeat (3) @(negedge clk);
    r.run = 1'b0; r.step = 1'b0; r.clr = 1'b0; r.req = "R1";
    compare(r); // R1 reset state
    rst_n = 1'b1;
    drive(0, 0, 1, 1, "R1");  // held through reset: no strobes
    drive(0, 0, 0, 0, "R1");
    drive(0, 0, 1, 0, "R5");  // press: one step
    for (int k = 0; k < 3; k++) drive(0, 0, 1, 0, "R5"); // held: no more
    drive(0, 0, 0, 0, "R5");
    drive(1, 0, 0, 0, "R2");  // start
    drive(0, 0, 0, 0, "R2");  // stays running
    drive(0, 0, 1, 0, "R6");  // incr while running ignored
    drive(0, 1, 1, 0, "R3");  // stop, incr still held
    drive(0, 0, 1, 0, "R6");  // ignored press still held
    drive(0, 0, 0, 0, "R6");
    drive(0, 0, 1, 0, "R5");  // fresh press steps
    drive(0, 0, 0, 0, "R5");
    drive(1, 1, 0, 0, "R3");  // stop beats start
    drive(1, 0, 0, 0, "R2");
    drive(1, 0, 0, 1, "R4");  // clear beats start
    drive(1, 0, 0, 1, "R4");  // held clear: no second pulse, stays stopped
    drive(0, 0, 0, 0, "R4");
    drive(0, 0, 1, 1, "R7");  // incr and clear together: clear only
    drive(0, 0, 0, 0, "R7");
    drive(1, 0, 1, 0, "R6");  // incr with start: no step
    drive(0, 1, 0, 0, "R3");
    drive(0, 0, 0, 0, "R3");
    drive(0, 0, 0, 0, "R3");
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule